// File: doc/BRIEF.md
# Two-wire bus master control unit

This unit is the control, status and data register layer of a two-wire serial interface. It also tracks the state of the bus and generates START and STOP conditions. A processor reaches it through a small register port. That port has a control register, a status register holding a 5-bit condition code and a 2-bit prescaler, and a data register. An operation-complete flag, called "done" here, tells software that the last bus action has finished. The interrupt request follows that flag.

The unit drives the clock and data lines through active-high open-drain enables: 1 pulls the line low. It samples both lines through a synchronizer. A falling data edge while the clock is high marks the bus busy. A rising data edge while the clock is high marks it free. A start request made while the bus is busy is held until a STOP is seen on the bus. A stop request while not owning the bus puts nothing on the lines; it only returns the unit to its quiet, unaddressed state. The timing of the START and STOP conditions comes from a fixed divider `BASE_DIV`, scaled by four raised to the prescaler value.

Top module: `twb_ctrl`

## Requirements
- R1: With the unit enabled, the start bit (control bit 1) set and the bus free, the unit begins a START on the next clock. For `lim = BASE_DIV * 4**ps` cycles it pulls SDA low with SCL released. After that it holds both lines low and owns the bus.
- R2: If the start bit is set while the bus is busy, the lines are not touched until a STOP is seen. With `SYNC_STAGES` synchronizer stages, the START begins on the (`SYNC_STAGES`+2)-th clock after SDA rises while SCL is high.
- R3: The hardware never clears the start bit. Only a control-register write changes it.
- R4: A stop request (control bit 2) while owning the bus first releases SCL with SDA still low for `lim` cycles. It then releases SDA and waits `lim` more cycles. It then clears the stop bit itself and sets the status code to the idle value.
- R5: A stop request while not owning the bus drives neither line. It clears the stop bit on the clock after it is set and leaves the status code at the idle value.
- R6: A data-register write (address 2) while done is 0 sets the collision flag (control bit 6) and leaves the data register unchanged. A data-register write while done is 1 stores the byte and clears the collision flag.
- R7: When the enable bit (control bit 0) reads 0, both line enables are 0 in that same cycle. Any START or STOP in progress is abandoned. Done clears on the following clock, the status code returns to the idle value, and the bus counts as free.
- R8: The interrupt output equals done AND interrupt-enable (control bit 3) AND the global enable input.
- R9: Address 0 reads {done[7], collision[6], 0[5:4], irq-enable[3], stop[2], start[1], enable[0]}. Address 1 reads {code[7:3], 0[2], prescaler[1:0]}; only the prescaler bits are writable there. After reset address 1 reads 0xF8 and address 0 reads 0x00. When a START completes, done is set and address 1 reads code 0x08 (with the prescaler bits). Writing a 1 to control bit 7 clears done.
- R10: The START hold time and the STOP phase times scale with the prescaler field: `lim` is `BASE_DIV` times 1, 4, 16 or 64 for prescaler 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| gie | input | 1 | Global interrupt enable |
| scl_in | input | 1 | Sampled clock line |
| sda_in | input | 1 | Sampled data line |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume that every register write is a single-cycle strobe. They also assume that software never writes the stop bit in the very cycle the hardware clears it, and that the lines seen on `scl_in` and `sda_in` are the wired-AND of this unit's enables and any other driver. The bench models the bus as exactly that wired-AND. It changes each external line only at negative clock edges. It never issues a write on the edge where a stop completes, and it makes external START and STOP conditions only while the unit is enabled.

// File: rtl/twb_pkg.sv
package twb_pkg;
   localparam int CODE_W = 5;
   localparam int PS_W   = 2;

   localparam int RA_CTRL = 0;
   localparam int RA_STAT = 1;
   localparam int RA_DATA = 2;

   localparam int B_EN    = 0;
   localparam int B_START = 1;
   localparam int B_STOP  = 2;
   localparam int B_IE    = 3;
   localparam int B_COLL  = 6;
   localparam int B_DONE  = 7;

   localparam logic [CODE_W-1:0] CODE_IDLE    = 5'h1F;
   localparam logic [CODE_W-1:0] CODE_STARTED = 5'h01;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_START,
      SQ_MASTER,
      SQ_STOP1,
      SQ_STOP2
   } sq_state_t;
endpackage

// File: rtl/twb_busmon.sv
module twb_busmon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic scl_in,
   input  logic sda_in,
   output logic busy
);
   logic scl_s, sda_s;
   logic scl_p, sda_p;
   logic start_seen, stop_seen;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("twb_busmon: SYNC_STAGES must be 0..4");
   end

   if (SYNC_STAGES == 0) begin : g_nosync
      assign scl_s = scl_in;
      assign sda_s = sda_in;
   end else begin : g_sync
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_st
         logic scl_r, sda_r;
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_r <= 1'b1;
                  sda_r <= 1'b1;
               end else begin
                  scl_r <= scl_in;
                  sda_r <= sda_in;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_r <= 1'b1;
                  sda_r <= 1'b1;
               end else begin
                  scl_r <= g_st[i-1].scl_r;
                  sda_r <= g_st[i-1].sda_r;
               end
            end
         end
      end
      assign scl_s = g_st[SYNC_STAGES-1].scl_r;
      assign sda_s = g_st[SYNC_STAGES-1].sda_r;
   end

   assign start_seen = scl_p && scl_s && sda_p && !sda_s;
   assign stop_seen  = scl_p && scl_s && !sda_p && sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
         busy  <= 1'b0;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
         if (!en)             busy <= 1'b0;
         else if (start_seen) busy <= 1'b1;
         else if (stop_seen)  busy <= 1'b0;
      end
   end
endmodule

// File: rtl/twb_seq.sv
module twb_seq import twb_pkg::*; #(
   parameter int BASE_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              start_req,
   input  logic              stop_req,
   input  logic              busy,
   input  logic [PS_W-1:0]   ps,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              done_set,
   output logic              stop_clr,
   output logic [CODE_W-1:0] code
);
   localparam int SHIFT_MAX = 2 * ((1 << PS_W) - 1);
   localparam int CNT_W     = $clog2(BASE_DIV + 1) + SHIFT_MAX + 1;

   if (BASE_DIV < 1) begin : g_bad_div
      $error("twb_seq: BASE_DIV must be at least 1");
   end

   sq_state_t        state, state_n;
   logic [CNT_W-1:0] cnt, cnt_n, lim;
   logic [CODE_W-1:0] code_n;
   logic             cnt_last;

   assign lim      = CNT_W'(BASE_DIV) << {ps, 1'b0};
   assign cnt_last = (cnt == lim - CNT_W'(1));

   always_comb begin
      state_n  = state;
      cnt_n    = cnt;
      code_n   = code;
      done_set = 1'b0;
      stop_clr = 1'b0;
      if (!en) begin
         state_n = SQ_IDLE;
         cnt_n   = '0;
         code_n  = CODE_IDLE;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (stop_req) begin
                  stop_clr = 1'b1;
                  code_n   = CODE_IDLE;
               end else if (start_req && !busy) begin
                  state_n = SQ_START;
                  cnt_n   = '0;
               end
            end
            SQ_START: begin
               if (cnt_last) begin
                  state_n  = SQ_MASTER;
                  cnt_n    = '0;
                  done_set = 1'b1;
                  code_n   = CODE_STARTED;
               end else begin
                  cnt_n = cnt + CNT_W'(1);
               end
            end
            SQ_MASTER: begin
               if (stop_req) begin
                  state_n = SQ_STOP1;
                  cnt_n   = '0;
               end
            end
            SQ_STOP1: begin
               if (cnt_last) begin
                  state_n = SQ_STOP2;
                  cnt_n   = '0;
               end else begin
                  cnt_n = cnt + CNT_W'(1);
               end
            end
            SQ_STOP2: begin
               if (cnt_last) begin
                  state_n  = SQ_IDLE;
                  cnt_n    = '0;
                  stop_clr = 1'b1;
                  code_n   = CODE_IDLE;
               end else begin
                  cnt_n = cnt + CNT_W'(1);
               end
            end
            default: begin
               state_n = SQ_IDLE;
               cnt_n   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         cnt   <= '0;
         code  <= CODE_IDLE;
      end else begin
         state <= state_n;
         cnt   <= cnt_n;
         code  <= code_n;
      end
   end

   assign sda_oe = en && (state == SQ_START || state == SQ_MASTER || state == SQ_STOP1);
   assign scl_oe = en && (state == SQ_MASTER);

   // R2: a START is only entered from a free bus
   assert_start_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == SQ_START) |-> $past(!busy));

   // R9: owning the bus comes with the started code
   assert_started_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == SQ_MASTER) |-> code == CODE_STARTED);

   // R4: SDA is released only after SCL was already released
   assert_stop_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sda_oe) && en) |-> !$past(scl_oe));
endmodule

// File: rtl/twb_regs.sv
module twb_regs import twb_pkg::*; #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              done_set,
   input  logic              stop_clr,
   input  logic [CODE_W-1:0] code,
   output logic              en,
   output logic              start_req,
   output logic              stop_req,
   output logic              irq_en,
   output logic              done,
   output logic [PS_W-1:0]   ps,
   output logic [DATA_W-1:0] rdata
);
   if (DATA_W < 8) begin : g_bad_w
      $error("twb_regs: DATA_W must be at least 8");
   end
   if (ADDR_W < 2) begin : g_bad_a
      $error("twb_regs: ADDR_W must be at least 2");
   end

   logic              coll;
   logic [DATA_W-1:0] data_q;
   logic              wr_ctrl, wr_stat, wr_data;
   logic [7:0]        ctrl_byte, stat_byte;

   assign wr_ctrl = wr_en && (addr == ADDR_W'(RA_CTRL));
   assign wr_stat = wr_en && (addr == ADDR_W'(RA_STAT));
   assign wr_data = wr_en && (addr == ADDR_W'(RA_DATA));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en        <= 1'b0;
         start_req <= 1'b0;
         stop_req  <= 1'b0;
         irq_en    <= 1'b0;
         done      <= 1'b0;
         coll      <= 1'b0;
         ps        <= '0;
         data_q    <= '0;
      end else begin
         if (wr_ctrl) begin
            en        <= wdata[B_EN];
            start_req <= wdata[B_START];
            irq_en    <= wdata[B_IE];
         end
         if (stop_clr)     stop_req <= 1'b0;
         else if (wr_ctrl) stop_req <= wdata[B_STOP];
         else if (!en)     stop_req <= 1'b0;
         if (done_set)                        done <= 1'b1;
         else if (!en)                        done <= 1'b0;
         else if (wr_ctrl && wdata[B_DONE])   done <= 1'b0;
         if (wr_stat) ps <= wdata[PS_W-1:0];
         if (wr_data) begin
            if (done) begin
               data_q <= wdata;
               coll   <= 1'b0;
            end else begin
               coll <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      ctrl_byte         = '0;
      ctrl_byte[B_EN]   = en;
      ctrl_byte[B_START]= start_req;
      ctrl_byte[B_STOP] = stop_req;
      ctrl_byte[B_IE]   = irq_en;
      ctrl_byte[B_COLL] = coll;
      ctrl_byte[B_DONE] = done;
      stat_byte         = {code, 1'b0, ps};
      rdata             = '0;
      if (addr == ADDR_W'(RA_CTRL))      rdata = DATA_W'(ctrl_byte);
      else if (addr == ADDR_W'(RA_STAT)) rdata = DATA_W'(stat_byte);
      else if (addr == ADDR_W'(RA_DATA)) rdata = data_q;
   end

   // R6: a rejected data write leaves the data register untouched
   assert_coll_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(coll) |-> $stable(data_q));

   // R3: only software clears the start bit
   assert_start_sw_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(start_req) |-> $past(wr_ctrl));

   // R4: the stop bit falls only on a hardware clear, a write or a disable
   assert_stop_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_req) |-> ($past(stop_clr) || $past(wr_ctrl) || $past(!en)));
endmodule

// File: rtl/twb_ctrl.sv
module twb_ctrl import twb_pkg::*; #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int BASE_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              gie,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              irq
);
   logic              en, start_req, stop_req, irq_en, done;
   logic              busy, done_set, stop_clr;
   logic [PS_W-1:0]   ps;
   logic [CODE_W-1:0] code;

   twb_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .done_set(done_set), .stop_clr(stop_clr), .code(code),
      .en(en), .start_req(start_req), .stop_req(stop_req), .irq_en(irq_en),
      .done(done), .ps(ps), .rdata(reg_rdata)
   );

   twb_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in), .sda_in(sda_in), .busy(busy)
   );

   twb_seq #(.BASE_DIV(BASE_DIV)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .start_req(start_req), .stop_req(stop_req),
      .busy(busy), .ps(ps), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .done_set(done_set), .stop_clr(stop_clr), .code(code)
   );

   assign irq = done && irq_en && gie;

   // R7: a disabled unit leaves both lines alone
   assert_off_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/twb_ctrl_tb.sv
module twb_ctrl_tb;
   localparam int CLK_PERIOD  = 10;
   localparam int BASE_DIV    = 4;
   localparam int SYNC_STAGES = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       gie = 1'b0;
   logic       ext_scl_low = 1'b0, ext_sda_low = 1'b0;
   logic       scl_in, sda_in, scl_oe, sda_oe, irq;

   int checks = 0;
   int errors = 0;

   assign scl_in = !(scl_oe || ext_scl_low);
   assign sda_in = !(sda_oe || ext_sda_low);

   always #(CLK_PERIOD/2) clk = !clk;

   twb_ctrl #(.DATA_W(8), .ADDR_W(2), .BASE_DIV(BASE_DIV), .SYNC_STAGES(SYNC_STAGES)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .gie(gie), .scl_in(scl_in), .sda_in(sda_in),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
   );

   // behavioural reference model
   bit       m_en, m_start, m_stop, m_ie, m_done, m_coll, m_busy, m_pscl, m_psda;
   bit [1:0] m_ps;
   bit [7:0] m_data;
   bit [4:0] m_code;
   int       m_st, m_cnt;
   bit       m_scl_q[$];
   bit       m_sda_q[$];

   function automatic bit [7:0] m_rd(input bit [1:0] a);
      case (a)
         2'd0: return {m_done, m_coll, 2'b00, m_ie, m_stop, m_start, m_en};
         2'd1: return {m_code, 1'b0, m_ps};
         2'd2: return m_data;
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_start = 0; m_stop = 0; m_ie = 0; m_done = 0; m_coll = 0;
         m_busy = 0; m_pscl = 1; m_psda = 1; m_ps = 0; m_data = 0; m_code = 5'h1F;
         m_st = 0; m_cnt = 0;
         m_scl_q.delete(); m_sda_q.delete();
         repeat (SYNC_STAGES) begin m_scl_q.push_back(1'b1); m_sda_q.push_back(1'b1); end
      end else begin
         bit sl, dl, ss, ds, sdet, pdet, dset, sclr, nbusy, wc, ws, wd;
         int lim, nst, ncnt;
         bit [4:0] ncode;
         sl = !((m_en && m_st == 2) || ext_scl_low);
         dl = !((m_en && (m_st == 1 || m_st == 2 || m_st == 3)) || ext_sda_low);
         ss = m_scl_q[0];
         ds = m_sda_q[0];
         sdet = m_pscl && ss && m_psda && !ds;
         pdet = m_pscl && ss && !m_psda && ds;
         nbusy = !m_en ? 1'b0 : sdet ? 1'b1 : pdet ? 1'b0 : m_busy;
         lim = BASE_DIV << (2 * m_ps);
         dset = 0; sclr = 0; nst = m_st; ncnt = m_cnt; ncode = m_code;
         if (!m_en) begin
            nst = 0; ncnt = 0; ncode = 5'h1F;
         end else begin
            case (m_st)
               0: if (m_stop) begin sclr = 1; ncode = 5'h1F; end
                  else if (m_start && !m_busy) begin nst = 1; ncnt = 0; end
               1: if (m_cnt == lim - 1) begin nst = 2; ncnt = 0; dset = 1; ncode = 5'h01; end
                  else ncnt = m_cnt + 1;
               2: if (m_stop) begin nst = 3; ncnt = 0; end
               3: if (m_cnt == lim - 1) begin nst = 4; ncnt = 0; end
                  else ncnt = m_cnt + 1;
               default: if (m_cnt == lim - 1) begin nst = 0; ncnt = 0; sclr = 1; ncode = 5'h1F; end
                  else ncnt = m_cnt + 1;
            endcase
         end
         wc = reg_wr && reg_addr == 2'd0;
         ws = reg_wr && reg_addr == 2'd1;
         wd = reg_wr && reg_addr == 2'd2;
         if (wd) begin
            if (m_done) begin m_data = reg_wdata; m_coll = 0; end
            else m_coll = 1;
         end
         if (dset) m_done = 1;
         else if (!m_en) m_done = 0;
         else if (wc && reg_wdata[7]) m_done = 0;
         if (sclr) m_stop = 0;
         else if (wc) m_stop = reg_wdata[2];
         else if (!m_en) m_stop = 0;
         if (ws) m_ps = reg_wdata[1:0];
         if (wc) begin m_en = reg_wdata[0]; m_start = reg_wdata[1]; m_ie = reg_wdata[3]; end
         m_pscl = ss; m_psda = ds;
         void'(m_scl_q.pop_front()); m_scl_q.push_back(sl);
         void'(m_sda_q.pop_front()); m_sda_q.push_back(dl);
         m_busy = nbusy; m_st = nst; m_cnt = ncnt; m_code = ncode;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         chk("R1", "lines", {scl_oe, sda_oe},
             {m_en && m_st == 2, m_en && (m_st == 1 || m_st == 2 || m_st == 3)});
         chk("R8", "irq", irq, m_done && m_ie && gie);
         chk("R9", "rdata", reg_rdata, m_rd(reg_addr));
      end
   end

   task automatic wr(input bit [1:0] a, input bit [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input bit [1:0] a, output bit [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #3;
      d = reg_rdata;
   endtask

   task automatic wait_irq();
      for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
      #1;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      bit [7:0] d;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state (R9)
      rd(2'd1, d); chk("R9", "status after reset", d, 8'hF8);
      rd(2'd0, d); chk("R9", "control after reset", d, 8'h00);

      // collision while done is low (R6)
      wr(2'd2, 8'hA5);
      rd(2'd0, d); chk("R6", "collision flag set", d, 8'h40);
      rd(2'd2, d); chk("R6", "data kept", d, 8'h00);

      // start on a free bus (R1, R3, R8, R9)
      gie = 1'b1;
      wr(2'd0, 8'h0B);
      wait_irq();
      chk("R8", "irq on done", irq, 1);
      chk("R1", "both lines held after start", {scl_oe, sda_oe}, 2'b11);
      rd(2'd0, d); chk("R3", "start bit kept, done set", d, 8'hCB);
      rd(2'd1, d); chk("R9", "started code", d, 8'h08);

      // accepted data write clears collision (R6)
      wr(2'd2, 8'h3C);
      rd(2'd2, d); chk("R6", "data stored", d, 8'h3C);
      rd(2'd0, d); chk("R6", "collision cleared", d, 8'h8B);

      // global enable gates the interrupt (R8)
      gie = 1'b0;
      @(negedge clk); #1;
      chk("R8", "irq gated by gie", irq, 0);
      gie = 1'b1;

      // stop while owning the bus (R4)
      wr(2'd0, 8'h8D);
      n = 0;
      for (int i = 0; i < 2000 && reg_rdata[2]; i++) begin
         @(negedge clk); #1;
         if (sda_oe && !scl_oe) n++;
      end
      chk("R4", "stop setup cycles", n, BASE_DIV);
      chk("R4", "lines released after stop", {scl_oe, sda_oe}, 2'b00);
      rd(2'd1, d); chk("R4", "idle code after stop", d, 8'hF8);

      // prescaler scales the start hold (R10)
      wr(2'd1, 8'h02);
      wr(2'd0, 8'h0B);
      n = 0;
      for (int i = 0; i < 2000 && !scl_oe; i++) begin
         @(negedge clk); #1;
         if (sda_oe && !scl_oe) n++;
      end
      chk("R10", "start hold at prescaler 2", n, BASE_DIV * 16);

      // disable in the middle of ownership (R7)
      wr(2'd0, 8'h00);
      chk("R7", "lines released on disable", {scl_oe, sda_oe}, 2'b00);
      rd(2'd0, d); chk("R7", "control after disable", d, 8'h00);
      rd(2'd1, d); chk("R7", "status after disable", d, 8'hFA);

      // start held while another master owns the bus (R2)
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h09);
      ext_sda_low = 1'b1;
      repeat (3) @(negedge clk);
      ext_scl_low = 1'b1;
      repeat (8) @(negedge clk);
      wr(2'd0, 8'h0B);
      repeat (50) @(negedge clk);
      #1;
      chk("R2", "no drive while busy", {scl_oe, sda_oe}, 2'b00);
      ext_scl_low = 1'b0;
      repeat (3) @(negedge clk);
      ext_sda_low = 1'b0;
      n = 0;
      for (int i = 0; i < 200 && !sda_oe; i++) begin
         @(negedge clk); #1;
         n++;
      end
      chk("R2", "start delay after stop", n, SYNC_STAGES + 2);
      wait_irq();
      rd(2'd1, d); chk("R2", "start completed after wait", d, 8'h08);

      // stop request while not owning the bus (R5)
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h09);
      repeat (4) @(negedge clk);
      wr(2'd0, 8'h0D);
      #1;
      chk("R5", "no drive on slave stop", {scl_oe, sda_oe}, 2'b00);
      rd(2'd0, d); chk("R5", "stop bit cleared", d, 8'h09);
      chk("R5", "still no drive", {scl_oe, sda_oe}, 2'b00);
      rd(2'd1, d); chk("R5", "idle code kept", d, 8'hF8);

      // collision again keeps the older byte (R6)
      wr(2'd2, 8'h77);
      rd(2'd2, d); chk("R6", "data kept on collision", d, 8'h3C);
      rd(2'd0, d); chk("R6", "collision flag again", d, 8'h49);

      repeat (5) @(negedge clk);
      summary();
      $finish;
   end
endmodule